// File: doc/BRIEF.md
# Late-Write Synchronous Static Memory Core

This block is a single-clock synchronous static memory with 18-bit words made of two 9-bit byte lanes. Address and command are registered on the rising clock edge. Read data is driven in the cycle that follows the command. Write data follows its address by one cycle ("late write"): the data is presented in the cycle after the write command and captured at the edge that ends that cycle. Captured data waits in a pending-write register and is committed to the array at the next clock edge. A comparator between the read address register and the pending write address merges the pending bytes over the array word, so a read always returns the newest data.

The external bidirectional bus is split into `wdata`, `rdata` and `rdata_en`. An asynchronous active-low output enable gates the bus drive without a clock. Read cycles issued while it is high are dummy reads. An asynchronous sleep input turns the drive off at once, and any command or write data sampled while it is high is ignored. The command stage is a three-state machine. It enters CMD_NONE on reset, on sleep or on a deselected cycle. It enters CMD_READ on a selected cycle with write enable high. It enters CMD_WRITE on a selected cycle with write enable low. Every state can move to any state at each edge.

Top module: `lw_sram`

## Requirements
- R1: After reset `rdata_en` is low, and no write is pending.
- R2: With sleep low, `sel_n` low and `wr_n` high at an edge, `rdata` carries the word at `addr` and `rdata_en` is high during the next cycle (when `oe_n` is low).
- R3: With sleep low, `sel_n` low and `wr_n` low at an edge, the value on `wdata` at the following edge is the data written to `addr`. This holds whatever `sel_n` is at that following edge.
- R4: `lane_n[0]` (active low) enables bits 8:0 and `lane_n[1]` enables bits 17:9. Both low writes the whole word. One low writes only its lane. Both high changes no bit.
- R5: A read whose command edge is the same edge that captures a write's data to that address returns the new bytes in the written lanes and the old bytes elsewhere.
- R6: Two writes on consecutive edges to the same address with different lanes both take effect.
- R7: With `sel_n` high at an edge, no operation starts: `rdata_en` is low in the next cycle and memory is unchanged.
- R8: `oe_n` high forces `rdata_en` low at once with no clock. A read in that cycle is a dummy read that changes no memory.
- R9: `sleep` high forces `rdata_en` low at once. A command sampled with sleep high is ignored, and so is write data sampled with sleep high.
- R10: A read to another address issued in a write's data cycle returns its own word, and the write still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sleep | input | 1 | Asynchronous sleep; forces bus off and ignores commands |
| sel_n | input | 1 | Synchronous select, active low |
| wr_n | input | 1 | Synchronous write enable, active low |
| lane_n | input | 2 | Synchronous lane write enables, active low |
| addr | input | AW | Synchronous word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 18 | Write data, sampled one edge after the write command |
| rdata | output | 18 | Read data |
| rdata_en | output | 1 | Bus drive enable for `rdata` |

## Verification
The late write capture and a new read command can share one edge. When both target the same address, the read must see the just-captured lanes before they reach the array. The bench provokes this with a write followed at once by a read of the same address, using full and partial lane masks, and with two stacked partial writes followed by a read. A behavioural model updates its memory at the capture edge and is compared with the bus on every cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_t;
endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_n,
    input  logic [AW-1:0]    addr,
    output logic [AW-1:0]    rd_addr_q,
    output logic [AW-1:0]    wr_addr_q,
    output logic [LANES-1:0] wr_mask_q,
    output logic             rd_active,
    output logic             wr_active
);
    cmd_t cmd_q, cmd_d;

    always_comb begin
        if (sleep || sel_n) begin
            cmd_d = CMD_NONE;
        end else if (!wr_n) begin
            cmd_d = CMD_WRITE;
        end else begin
            cmd_d = CMD_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NONE;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            wr_mask_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            if (cmd_d == CMD_READ) begin
                rd_addr_q <= addr;
            end
            if (cmd_d == CMD_WRITE) begin
                wr_addr_q <= addr;
                wr_mask_q <= ~lane_n;
            end
        end
    end

    always_comb begin
        rd_active = 1'b0;
        wr_active = 1'b0;
        unique case (cmd_q)
            CMD_NONE:  ;
            CMD_READ:  rd_active = 1'b1;
            CMD_WRITE: wr_active = 1'b1;
            default:   ;
        endcase
    end

    // R2: a selected read edge leads to a read state
    p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && wr_n) |=> rd_active);

    // R7: a deselected edge starts nothing
    p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || sleep) |=> (!rd_active && !wr_active));
endmodule

// File: rtl/lw_pend.sv
module lw_pend
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [AW-1:0]     cap_addr,
    input  logic [LANES-1:0]  cap_mask,
    input  logic [WORD_W-1:0] cap_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] arr_data,
    output logic              commit_en,
    output logic [AW-1:0]     commit_addr,
    output logic [LANES-1:0]  commit_mask,
    output logic [WORD_W-1:0] commit_data,
    output logic [WORD_W-1:0] merged
);
    logic              pv_q;
    logic [AW-1:0]     pa_q;
    logic [LANES-1:0]  pm_q;
    logic [WORD_W-1:0] pd_q;
    logic              hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q <= 1'b0;
            pa_q <= '0;
            pm_q <= '0;
            pd_q <= '0;
        end else begin
            pv_q <= cap_en;
            if (cap_en) begin
                pa_q <= cap_addr;
                pm_q <= cap_mask;
                pd_q <= cap_data;
            end
        end
    end

    assign hit         = pv_q && (pa_q == rd_addr);
    assign commit_en   = pv_q;
    assign commit_addr = pa_q;
    assign commit_mask = pm_q;
    assign commit_data = pd_q;

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = (hit && pm_q[l]) ?
            pd_q[l*LANE_W +: LANE_W] : arr_data[l*LANE_W +: LANE_W];
    end

    // R3: captured data is held pending after the capture edge
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (commit_en && commit_data == $past(cap_data)));
endmodule

// File: rtl/lw_array.sv
module lw_array
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANES-1:0]  wmask,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wmask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end
        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [AW-1:0]     addr,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_en
);
    logic [AW-1:0]     rd_addr_q, wr_addr_q, c_addr;
    logic [LANES-1:0]  wr_mask_q, c_mask;
    logic              rd_active, wr_active, c_en;
    logic [WORD_W-1:0] arr_q, c_data;

    lw_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n),
        .wr_n(wr_n), .lane_n(lane_n), .addr(addr),
        .rd_addr_q(rd_addr_q), .wr_addr_q(wr_addr_q), .wr_mask_q(wr_mask_q),
        .rd_active(rd_active), .wr_active(wr_active)
    );

    lw_pend #(.AW(AW)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .cap_en(wr_active && !sleep), .cap_addr(wr_addr_q),
        .cap_mask(wr_mask_q), .cap_data(wdata),
        .rd_addr(rd_addr_q), .arr_data(arr_q),
        .commit_en(c_en), .commit_addr(c_addr), .commit_mask(c_mask),
        .commit_data(c_data), .merged(rdata)
    );

    lw_array #(.AW(AW)) u_array (
        .clk(clk), .we(c_en), .waddr(c_addr), .wmask(c_mask),
        .wdata(c_data), .raddr(rd_addr_q), .rdata(arr_q)
    );

    assign rdata_en = rd_active && !sleep && !oe_n;

    always_comb begin
        if (sleep) begin
            p_oe_sleep_r9: assert (!rdata_en);
        end
        if (oe_n) begin
            p_oe_gate_r8: assert (!rdata_en);
        end
    end

    // R1: no bus drive in the first cycle after reset
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rdata_en);
endmodule

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
    localparam int P  = 10;
    localparam int AW = 4;
    localparam int W  = 18;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0, sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0;
    logic [1:0] lane_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rdata_en;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    logic [W-1:0] mm [DEPTH];
    logic pw = 1'b0;
    logic [AW-1:0] pw_addr = '0;
    logic [1:0] pw_mask = '0;
    logic exp_rd = 1'b0;
    logic [W-1:0] exp_data = '0;

    always #(P/2) clk = ~clk;

    lw_sram #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
        .lane_n(lane_n), .addr(addr), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    // reference model: memory updated at the data capture edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (pw && !sleep) begin
                if (pw_mask[0]) mm[pw_addr][8:0]  = wdata[8:0];
                if (pw_mask[1]) mm[pw_addr][17:9] = wdata[17:9];
            end
            pw = 1'b0;
            exp_rd = 1'b0;
            if (!sleep && !sel_n) begin
                if (!wr_n) begin
                    pw = 1'b1;
                    pw_addr = addr;
                    pw_mask = ~lane_n;
                end else begin
                    exp_rd = 1'b1;
                    exp_data = mm[addr];
                end
            end
        end
    end

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(input logic s_n, input logic w_n, input logic [1:0] ln,
                        input int a, input logic [W-1:0] d, input logic o_n,
                        input logic slp, input string req);
        @(negedge clk);
        sel_n = s_n; wr_n = w_n; lane_n = ln; addr = AW'(a);
        wdata = d; oe_n = o_n; sleep = slp; cur_req = req;
        @(posedge clk);
        #(P/4);
        check(W'(rdata_en), W'(exp_rd && !sleep && !oe_n), "rdata_en");
        if (exp_rd && !sleep && !oe_n) check(rdata, exp_data, "rdata");
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'(i * 18'h02d3) ^ 18'h15a5a;
    endfunction

    initial begin
        #(P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(P/4);
        cur_req = "R1";
        check(W'(rdata_en), '0, "rdata_en in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #(P/4);
        check(W'(rdata_en), '0, "rdata_en after reset");

        // R3: back-to-back full writes fill memory
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 2'b00, i, (i == 0) ? '0 : pat(i-1), 1'b0, 1'b0, "R3");
        step(1'b1, 1'b1, 2'b11, 0, pat(DEPTH-1), 1'b0, 1'b0, "R3");
        // R2: read everything back
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b1, 2'b11, i, '0, 1'b0, 1'b0, "R2");

        // R4: lane masks, lane a bits 8:0 via lane_n[0]
        step(1'b0, 1'b0, 2'b10, 3, '0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b1, 2'b11, 0, 18'h3ffff, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 2'b01, 3, '0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b1, 2'b11, 0, 18'h00000, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 2'b11, 3, '0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b1, 2'b11, 0, 18'h12345, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 2'b11, 3, '0, 1'b0, 1'b0, "R4");

        // R5: read issued on the capture edge of the same address
        step(1'b0, 1'b0, 2'b00, 5, '0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 2'b11, 5, 18'h2aaaa, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 2'b01, 5, '0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 2'b11, 5, 18'h15555, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 2'b11, 5, '0, 1'b0, 1'b0, "R5");

        // R6: stacked partial writes to one address
        step(1'b0, 1'b0, 2'b10, 7, '0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 2'b01, 7, 18'h0f0f0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 2'b11, 7, 18'h30303, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 2'b11, 7, '0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 2'b11, 0, '0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 2'b11, 7, '0, 1'b0, 1'b0, "R6");

        // R7: deselected write command does nothing; data cycle ignores sel_n
        step(1'b1, 1'b0, 2'b00, 9, '0, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b1, 2'b11, 9, 18'h3c3c3, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 2'b11, 9, '0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 2'b00, 10, '0, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 2'b00, 10, 18'h0abcd, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 2'b11, 10, '0, 1'b0, 1'b0, "R3");

        // R8: dummy read and asynchronous gating
        step(1'b0, 1'b1, 2'b11, 2, '0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 2'b11, 2, '0, 1'b0, 1'b0, "R8");
        #1 oe_n = 1'b1; #1;
        check(W'(rdata_en), '0, "rdata_en after async oe_n");
        oe_n = 1'b0; #1;
        check(W'(rdata_en), 18'd1, "rdata_en after oe_n release");

        // R9: sleep gating and ignored commands and data
        step(1'b0, 1'b1, 2'b11, 4, '0, 1'b0, 1'b0, "R9");
        #1 sleep = 1'b1; #1;
        check(W'(rdata_en), '0, "rdata_en after async sleep");
        step(1'b0, 1'b0, 2'b00, 4, '0, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b1, 2'b11, 4, 18'h11111, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 2'b00, 6, '0, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 2'b11, 6, 18'h22222, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, 2'b11, 4, '0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 2'b11, 6, '0, 1'b0, 1'b0, "R9");

        // R10: turnaround to another address in the data cycle
        step(1'b0, 1'b0, 2'b00, 11, '0, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b1, 2'b11, 12, 18'h1beef, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b1, 2'b11, 11, '0, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b1, 2'b11, 0, '0, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b1, 2'b11, 11, '0, 1'b0, 1'b0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule